// File: doc/BRIEF.md
# Interval Timer Channel

This block is one channel of a programmable interval timer: a 16-bit down-counter advanced by a count strobe. It has a gate input and one output pin. A single configuration write supplies both a mode code and a count value. The mode selects one of six behaviours: a plain one-shot, a gate-triggered one-shot, a rate generator, a square-wave generator, a software strobe and a gate-triggered strobe. Each mode has its own rules for the gate, for reloading and for the output waveform.

The counter only moves on cycles where `tick_i` is high, so an outside prescaler sets the counting rate. Decoding of the bus, latching of reads and returning status to software all belong to a neighbouring block. That block reads `count_o`, `out_o` and `loaded_o` directly.

Top module: `ivt_channel`

## Requirements
- R1: While reset is asserted and afterwards until the first write, `count_o` is 0, `out_o` is low and `loaded_o` is low.
- R2: A write (`cfg_we_i` high) clears `loaded_o` in the next cycle. It sets `out_o` low for mode code 0 and high for every other code. Mode codes 0 to 5 select the six modes in the order listed above; codes 6 and 7 behave as codes 2 and 3. If `tick_i` is high in the same cycle as a write, that strobe is ignored. In modes 0, 2, 3 and 4 the first strobe after the write transfers the count into the counter and sets `loaded_o`.
- R3: A count value of 0 stands for 65536: after it is loaded the counter shows 0, and the next decrement gives 0xFFFF with no terminal action.
- R4: In mode 0, each strobe decrements the count only while the gate is high. When the count reaches 0, `out_o` goes high and counting stops. In this mode `out_o` only ever falls on a write.
- R5: In mode 1, a rising gate edge (seen at any clock since the previous strobe) loads the count on the next strobe and drives `out_o` low. Counting continues after the gate falls. At 0, `out_o` returns high. A new rising edge reloads the count.
- R6: In mode 2 with count N, `out_o` goes low for one strobe period when the count reaches 1. The next strobe reloads N and sets `out_o` high, giving a period of N strobes.
- R7: In modes 2 and 3, strobes while the gate is low leave the count unchanged. In mode 2, a low gate forces `out_o` high in the following cycle.
- R8: In mode 3, the count steps down by 2 per strobe and shows only even values once loaded. `out_o` stays high for ceil(N/2) strobes and low for floor(N/2) strobes, repeating.
- R9: In mode 4, the count is loaded on the first strobe with `out_o` high. Strobes with the gate high decrement it. On reaching 0, `out_o` is low for exactly one strobe period, then goes high again, and counting stops with no reload.
- R10: Mode 5 matches mode 4, except that loading happens on the strobe after a rising gate edge, and a later low gate does not stop the count.
- R11: Without `tick_i`, the count, the output and `loaded_o` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Count strobe, one clock wide |
| gate_i | input | 1 | Gate input |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 3 | Mode code for the write |
| cfg_count_i | input | 16 | Count value for the write |
| count_o | output | 16 | Live counter value |
| out_o | output | 1 | Output pin level |
| loaded_o | output | 1 | Written count has been moved into the counter |

## Verification
On every cycle, the assertions check these invariants: `loaded_o` clears after a write; a low gate in mode 2 forces the output high; the mode-3 count stays even; a mode-0 output never falls without a write; and a mode-4 low pulse ends on the next strobe. Full waveform shape needs the bench's scenarios, compared against a cycle-by-cycle reference. That covers square-wave phase lengths for odd and even counts, rate-generator period, gate triggering and retriggering in modes 1 and 5, the 65536 wrap of a zero count, and the mode-code aliases.

// File: rtl/ivt_pkg.sv
package ivt_pkg;

  typedef enum logic [2:0] {
    MD_ONESHOT  = 3'd0,
    MD_RETRIG   = 3'd1,
    MD_RATE     = 3'd2,
    MD_SQUARE   = 3'd3,
    MD_SWSTROBE = 3'd4,
    MD_HWSTROBE = 3'd5
  } ivt_mode_e;

  // codes 6 and 7 fold onto the rate and square modes
  function automatic ivt_mode_e ivt_decode(input logic [2:0] code);
    if (code[2:1] == 2'b11) return ivt_mode_e'({1'b0, code[1:0]});
    return ivt_mode_e'(code);
  endfunction

endpackage

// File: rtl/ivt_gate_sense.sv
module ivt_gate_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic gate_i,
  input  logic tick_i,
  input  logic clr_i,
  output logic trig_o
);
  logic gate_q, trig_q, trig_n;

  // a rising edge is held until the next strobe consumes it
  assign trig_o = trig_q | (gate_i & ~gate_q);

  always_comb begin
    trig_n = trig_o;
    if (tick_i || clr_i) trig_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      gate_q <= gate_i;
      trig_q <= trig_n;
    end
  end
endmodule

// File: rtl/ivt_cfg_reg.sv
module ivt_cfg_reg
  import ivt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  ivt_mode_e     mode_i,
  input  logic [CW-1:0] count_i,
  input  logic          xfer_i,
  output ivt_mode_e     mode_o,
  output logic [CW-1:0] reload_o,
  output logic          have_o,
  output logic          loaded_o
);
  ivt_mode_e     mode_q, mode_n;
  logic [CW-1:0] reload_q, reload_n;
  logic          have_q, have_n, loaded_q, loaded_n;

  always_comb begin
    mode_n   = mode_q;
    reload_n = reload_q;
    have_n   = have_q;
    loaded_n = loaded_q;
    if (we_i) begin
      mode_n   = mode_i;
      reload_n = count_i;
      have_n   = 1'b1;
      loaded_n = 1'b0;
    end else if (xfer_i) begin
      loaded_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MD_ONESHOT;
      reload_q <= '0;
      have_q   <= 1'b0;
      loaded_q <= 1'b0;
    end else begin
      mode_q   <= mode_n;
      reload_q <= reload_n;
      have_q   <= have_n;
      loaded_q <= loaded_n;
    end
  end

  assign mode_o   = mode_q;
  assign reload_o = reload_q;
  assign have_o   = have_q;
  assign loaded_o = loaded_q;
endmodule

// File: rtl/ivt_count_core.sv
module ivt_count_core
  import ivt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          gate_i,
  input  logic          trig_i,
  input  logic          we_i,
  input  ivt_mode_e     new_mode_i,
  input  ivt_mode_e     mode_i,
  input  logic [CW-1:0] reload_i,
  input  logic          have_i,
  input  logic          loaded_i,
  output logic [CW-1:0] cnt_o,
  output logic          out_o,
  output logic          xfer_o
);
  localparam logic [CW-1:0] ONE = CW'(1);
  localparam logic [CW-1:0] TWO = CW'(2);

  logic [CW-1:0] cnt_q, cnt_n, hi_val, lo_val;
  logic          out_q, out_n, armed_q, armed_n, pending;

  assign pending = have_i & ~loaded_i;
  // square-wave phase loads: odd counts give the high phase the extra strobe
  assign hi_val  = reload_i + CW'(reload_i[0]);
  assign lo_val  = reload_i - CW'(reload_i[0]);

  always_comb begin
    cnt_n   = cnt_q;
    out_n   = out_q;
    armed_n = armed_q;
    xfer_o  = 1'b0;
    if (we_i) begin
      armed_n = 1'b0;
      out_n   = (new_mode_i != MD_ONESHOT);
    end else begin
      if (tick_i) begin
        case (mode_i)
          MD_ONESHOT: begin
            if (pending) begin
              cnt_n = reload_i; armed_n = 1'b1; xfer_o = 1'b1;
            end else if (armed_q && gate_i) begin
              cnt_n = cnt_q - ONE;
              if (cnt_q == ONE) begin armed_n = 1'b0; out_n = 1'b1; end
            end
          end
          MD_RETRIG: begin
            if (have_i && trig_i) begin
              cnt_n = reload_i; armed_n = 1'b1; out_n = 1'b0; xfer_o = pending;
            end else if (armed_q) begin
              cnt_n = cnt_q - ONE;
              if (cnt_q == ONE) begin armed_n = 1'b0; out_n = 1'b1; end
            end
          end
          MD_RATE: begin
            if (pending) begin
              cnt_n = reload_i; xfer_o = 1'b1;
            end else if (gate_i) begin
              if (cnt_q == ONE) begin
                cnt_n = reload_i; out_n = 1'b1;
              end else begin
                cnt_n = cnt_q - ONE;
                if (cnt_q == TWO) out_n = 1'b0;
              end
            end
          end
          MD_SQUARE: begin
            if (pending) begin
              cnt_n = hi_val; out_n = 1'b1; xfer_o = 1'b1;
            end else if (gate_i) begin
              if (cnt_q == TWO) begin
                out_n = ~out_q;
                cnt_n = out_q ? lo_val : hi_val;
              end else begin
                cnt_n = cnt_q - TWO;
              end
            end
          end
          MD_SWSTROBE: begin
            if (!out_q) out_n = 1'b1;
            if (pending) begin
              cnt_n = reload_i; armed_n = 1'b1; xfer_o = 1'b1;
            end else if (armed_q && gate_i) begin
              cnt_n = cnt_q - ONE;
              if (cnt_q == ONE) begin armed_n = 1'b0; out_n = 1'b0; end
            end
          end
          MD_HWSTROBE: begin
            if (!out_q) out_n = 1'b1;
            if (have_i && trig_i) begin
              cnt_n = reload_i; armed_n = 1'b1; xfer_o = pending;
            end else if (armed_q) begin
              cnt_n = cnt_q - ONE;
              if (cnt_q == ONE) begin armed_n = 1'b0; out_n = 1'b0; end
            end
          end
          default: ;
        endcase
      end
      if (mode_i == MD_RATE && !gate_i) out_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      out_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      out_q   <= out_n;
      armed_q <= armed_n;
    end
  end

  assign cnt_o = cnt_q;
  assign out_o = out_q;
endmodule

// File: rtl/ivt_channel.sv
module ivt_channel
  import ivt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          gate_i,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_mode_i,
  input  logic [CW-1:0] cfg_count_i,
  output logic [CW-1:0] count_o,
  output logic          out_o,
  output logic          loaded_o
);
  ivt_mode_e     wr_mode, mode_q;
  logic [CW-1:0] reload;
  logic          have, trig, xfer;

  assign wr_mode = ivt_decode(cfg_mode_i);

  ivt_gate_sense u_gate (
    .clk(clk), .rst_n(rst_n), .gate_i(gate_i), .tick_i(tick_i),
    .clr_i(cfg_we_i), .trig_o(trig)
  );

  ivt_cfg_reg #(.CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .mode_i(wr_mode),
    .count_i(cfg_count_i), .xfer_i(xfer), .mode_o(mode_q),
    .reload_o(reload), .have_o(have), .loaded_o(loaded_o)
  );

  ivt_count_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .gate_i(gate_i),
    .trig_i(trig), .we_i(cfg_we_i), .new_mode_i(wr_mode), .mode_i(mode_q),
    .reload_i(reload), .have_i(have), .loaded_i(loaded_o),
    .cnt_o(count_o), .out_o(out_o), .xfer_o(xfer)
  );
endmodule

// File: rtl/ivt_channel_chk.sv
module ivt_channel_chk
  import ivt_pkg::*;
#(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick_i,
  input logic          gate_i,
  input logic          cfg_we_i,
  input logic [CW-1:0] count_o,
  input logic          out_o,
  input logic          loaded_o,
  input ivt_mode_e     mode_q
);
  a_r2_write_clears_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we_i |=> !loaded_o);

  a_r7_rate_gate_low_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_RATE && !gate_i && !cfg_we_i) |=> out_o);

  a_r8_square_even: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_SQUARE && loaded_o) |-> !count_o[0]);

  a_r4_oneshot_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(out_o) && mode_q == MD_ONESHOT) |-> $past(cfg_we_i));

  a_r9_strobe_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_SWSTROBE && !out_o && tick_i && !cfg_we_i) |=> out_o);
endmodule

bind ivt_channel ivt_channel_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .gate_i(gate_i),
  .cfg_we_i(cfg_we_i), .count_o(count_o), .out_o(out_o),
  .loaded_o(loaded_o), .mode_q(mode_q)
);

// File: tb/ivt_channel_test.sv
module ivt_channel_test;
  logic        clk = 1'b0;
  logic        rst_n, tick, gate, we;
  logic [2:0]  wmode;
  logic [15:0] wcount;
  logic [15:0] count_o;
  logic        out_o, loaded_o;

  int checks = 0, errors = 0;
  bit cmp_en = 0, done = 0;
  string cur_req = "R1";

  // reference state
  int m_mode, m_n, m_cnt;
  bit m_have, m_loaded, m_out, m_armed, m_gq, m_trig;

  always #10 clk = ~clk;

  ivt_channel uut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .gate_i(gate),
    .cfg_we_i(we), .cfg_mode_i(wmode), .cfg_count_i(wcount),
    .count_o(count_o), .out_o(out_o), .loaded_o(loaded_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // behavioural reference, updated on each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_n = 0; m_cnt = 0; m_have = 0; m_loaded = 0;
      m_out = 0; m_armed = 0; m_gq = 0; m_trig = 0;
    end else begin
      bit fire, pend;
      fire = m_trig || (gate && !m_gq);
      pend = m_have && !m_loaded;
      if (we) begin
        m_mode = (wmode >= 6) ? wmode - 4 : wmode;
        m_n = wcount; m_have = 1; m_loaded = 0; m_armed = 0;
        m_out = (m_mode != 0); m_trig = 0;
      end else begin
        if (tick) begin
          if (m_mode == 4 || m_mode == 5) m_out = 1;
          if ((m_mode == 1 || m_mode == 5) && fire) begin
            m_cnt = m_n; m_armed = 1; m_loaded = 1;
            if (m_mode == 1) m_out = 0;
          end else if (pend && m_mode != 1 && m_mode != 5) begin
            m_loaded = 1; m_out = (m_mode != 0);
            m_cnt = (m_mode == 3) ? (m_n + m_n % 2) % 65536 : m_n;
            m_armed = (m_mode == 0 || m_mode == 4);
          end else if (m_mode == 2) begin
            if (gate) begin
              if (m_cnt == 1) begin m_cnt = m_n; m_out = 1; end
              else begin m_cnt = (m_cnt + 65535) % 65536; if (m_cnt == 1) m_out = 0; end
            end
          end else if (m_mode == 3) begin
            if (gate) begin
              if (m_cnt == 2) begin
                m_cnt = m_out ? m_n - m_n % 2 : (m_n + m_n % 2) % 65536;
                m_out = !m_out;
              end else m_cnt = (m_cnt + 65534) % 65536;
            end
          end else if (m_armed && (gate || m_mode == 1 || m_mode == 5)) begin
            m_cnt = (m_cnt + 65535) % 65536;
            if (m_cnt == 0) begin
              m_armed = 0;
              m_out = (m_mode == 0 || m_mode == 1);
            end
          end
          m_trig = 0;
        end else m_trig = fire;
        if (m_mode == 2 && !gate) m_out = 1;
      end
      m_gq = gate;
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      check(cur_req, "count", count_o, m_cnt);
      check(cur_req, "out", out_o, m_out);
      check(cur_req, "loaded", loaded_o, m_loaded);
    end
  end

  task automatic step(input int n, input int div);
    for (int i = 0; i < n; i++) begin
      tick = (div != 0) && (i % div == 0);
      @(negedge clk);
    end
    tick = 1'b0;
  endtask

  task automatic wr(input int mode, input int cnt, input bit with_tick);
    we = 1'b1; wmode = 3'(mode); wcount = 16'(cnt); tick = with_tick;
    @(negedge clk);
    we = 1'b0; tick = 1'b0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1; errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [39:0] trace;
    int idx, hi_len, lo_len;
    rst_n = 0; tick = 0; gate = 0; we = 0; wmode = 0; wcount = 0;
    repeat (3) @(negedge clk);
    check("R1", "count in reset", count_o, 0);
    check("R1", "out in reset", out_o, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "loaded after reset", loaded_o, 0);
    check("R1", "count after reset", count_o, 0);
    cmp_en = 1;

    // R11: no strobes, nothing moves
    cur_req = "R11"; gate = 1;
    wr(4, 5, 0);
    step(6, 0);
    check("R11", "count without strobe", count_o, 0);
    check("R11", "loaded without strobe", loaded_o, 0);

    // R9: software strobe
    cur_req = "R9"; step(14, 1);
    cur_req = "R2"; wr(4, 3, 1);
    check("R2", "loaded cleared by write", loaded_o, 0);
    step(1, 1);
    check("R2", "first strobe loads", loaded_o, 1);
    check("R2", "first strobe count", count_o, 3);
    cur_req = "R9"; step(10, 2);

    // R4: one-shot with gate pause
    cur_req = "R4"; wr(0, 6, 0);
    check("R2", "mode 0 out low", out_o, 0);
    step(6, 2); gate = 0; step(8, 2); gate = 1; step(20, 2);
    check("R4", "terminal out", out_o, 1);

    // R5: gate-triggered one-shot
    cur_req = "R5"; gate = 0; wr(1, 4, 0);
    step(3, 1);
    check("R5", "waits for trigger", loaded_o, 0);
    gate = 1; step(2, 1); gate = 0; step(2, 1);
    check("R5", "counting continues after gate fall", out_o, 0);
    step(4, 1); gate = 1; step(3, 1); gate = 0; step(2, 1);
    gate = 1; step(8, 1);

    // R6 / R7: rate generator
    cur_req = "R6"; wr(2, 4, 0); step(14, 1);
    cur_req = "R7"; gate = 0; step(4, 1);
    check("R7", "rate gate low out", out_o, 1);
    gate = 1; step(9, 1);

    // R8: square wave, odd then even, with gate halt
    cur_req = "R8"; wr(3, 5, 0); step(4, 1);
    for (int i = 0; i < 40; i++) begin
      trace[i] = out_o;
      step(1, 1);
    end
    idx = 1;
    while (idx < 39 && !(trace[idx-1] == 1'b0 && trace[idx] == 1'b1)) idx++;
    hi_len = 0; while (idx < 40 && trace[idx]) begin hi_len++; idx++; end
    lo_len = 0; while (idx < 40 && !trace[idx]) begin lo_len++; idx++; end
    check("R8", "odd count high phase", hi_len, 3);
    check("R8", "odd count low phase", lo_len, 2);
    wr(3, 6, 0); step(16, 1);
    cur_req = "R7"; gate = 0; step(5, 1); gate = 1;
    cur_req = "R8"; step(6, 1);

    // R2: aliases 7 and 6
    cur_req = "R2"; wr(7, 4, 0); step(10, 1);
    wr(6, 3, 0); step(8, 1);

    // R10: gate-triggered strobe
    cur_req = "R10"; gate = 0; wr(5, 3, 0); step(3, 1);
    gate = 1; step(2, 1); gate = 0; step(6, 1);
    gate = 1; step(8, 2);

    // R3: zero means 65536
    cur_req = "R3"; gate = 1; wr(2, 0, 0);
    step(1, 1);
    check("R3", "zero count loaded", count_o, 0);
    step(1, 1);
    check("R3", "wrap after zero", count_o, 16'hFFFF);
    check("R3", "no terminal action", out_o, 1);
    step(4, 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule